// File: doc/BRIEF.md
# Temperature Sensor Control Unit

This block sits between a 32-bit register bus and an on-chip temperature sensor with its own ADC. Software turns the sensor and the ADC on through a mode register. The block then holds off measurement until a fixed warm-up time has passed. After that, a start command makes the block capture the 12-bit ADC code on its own, once per fixed interval. Each capture overwrites the result register. A running flag lets software poll whether captures are active.

Two read-only words expose factory trim data that arrive on input pins. Each word carries a valid flag and a 12-bit value. The warm-up time and the capture interval are given in microseconds (60 and 20). They are converted into clock cycles from the clock-frequency parameter: SETTLE_CYC = (CLK_HZ/1e6)*60 and INTERVAL_CYC = (CLK_HZ/1e6)*20. Reads are combinational from the address. Writes take effect at the clock edge where `bus_we` is high.

Top module: `thermsense_ctrl`

## Requirements
- R1: After synchronous reset, the mode register, the start register, the result register and the status register all read 0.
- R2: The mode register at offset 0x00 is read/write in bits 1:0. Bit 0 enables the sensor and bit 1 enables the ADC. Normal mode means both bits are 1. The other bits read 0.
- R3: Counting from the edge at which normal mode is entered, a write of 1 to bit 0 of the start register (offset 0x04) is honoured only if its write edge comes SETTLE_CYC or more edges later. An earlier start write is ignored, and the status flag stays 0. The block stays settled for as long as normal mode holds.
- R4: A start write made while the mode register is not 2'b11 is ignored.
- R5: After an honoured start, bit 0 of the status register (offset 0x10) reads 1 from the next cycle on. Bit 0 of the start register also reads back as 1.
- R6: While running, the result register (offset 0x0C) loads the ADC code into bits 11:0 at the edge that lies INTERVAL_CYC edges after the start edge, and then every INTERVAL_CYC edges. Between loads it holds its value. Bits 31:12 read 0.
- R7: Writing a mode value other than 2'b11 stops captures at once, so status reads 0 after that write edge. The result holds its last value. The warm-up restarts, so a later return to normal mode needs a full SETTLE_CYC again before a start is honoured.
- R8: Writing 0 to bit 0 of the start register stops captures, and the result then holds its value.
- R9: The trim words at offsets 0x18 and 0x1C show bit 31 and bits 11:0 of the inputs `trim0_word` and `trim1_word`. All other bits read 0. Bus writes to these offsets change nothing.
- R10: Offsets that are not mapped, such as 0x08 and 0x14, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| adc_code | input | 12 | Current conversion code from the ADC |
| trim0_word | input | 32 | First trim word (bit 31 valid, bits 11:0 value) |
| trim1_word | input | 32 | Second trim word (bit 31 valid, bits 11:0 value) |

## Verification
The bench places a start write one edge before the warm-up ends, then one exactly at its end. A design whose counter is off by one would either honour the early write or reject the on-time one. A table of ADC codes, including all-zeros and all-ones, is checked one edge before each expected load and again at the load edge. A pacer with the wrong phase would show the new code too early or too late. Stopping by mode clear and by writing start to 0 must leave the result frozen while the ADC input keeps changing. A re-entry into normal mode must demand a fresh warm-up, which catches a settle timer that fails to clear.

// File: rtl/thermsense_pkg.sv
package thermsense_pkg;

    localparam int CODE_W = 12;
    localparam int DATA_W = 32;

    // byte offsets of the register slots
    localparam int OFF_MODE   = 'h00;
    localparam int OFF_START  = 'h04;
    localparam int OFF_RESULT = 'h0C;
    localparam int OFF_STATUS = 'h10;
    localparam int OFF_TRIM0  = 'h18;
    localparam int OFF_TRIM1  = 'h1C;

    localparam int SETTLE_US   = 60;
    localparam int INTERVAL_US = 20;

    typedef logic [CODE_W-1:0] code_t;

    // bit 0 sensor enable, bit 1 ADC enable
    typedef struct packed {
        logic adc_en;
        logic sense_en;
    } mode_t;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_WARMING = 2'd1,
        PH_READY   = 2'd2
    } phase_e;

    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned us);
        int unsigned c;
        c = (clk_hz / 1000000) * us;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic [DATA_W-1:0] trim_view(input logic [DATA_W-1:0] w);
        return {w[31], 19'b0, w[CODE_W-1:0]};
    endfunction

endpackage

// File: rtl/tsc_mode_reg.sv
module tsc_mode_reg
    import thermsense_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wbits,
    output mode_t      mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (we) begin
            mode <= mode_t'(wbits);
        end
    end
endmodule

// File: rtl/tsc_settle.sv
module tsc_settle
    import thermsense_pkg::*;
#(
    parameter int SETTLE_CYC = 60
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   normal,
    output logic   ready,
    output phase_e phase
);
    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !normal) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (!normal)          phase = PH_OFF;
        else if (cnt == LAST) phase = PH_READY;
        else                  phase = PH_WARMING;
    end

    assign ready = (phase == PH_READY);
endmodule

// File: rtl/tsc_conv.sv
module tsc_conv
    import thermsense_pkg::*;
#(
    parameter int INTERVAL_CYC = 20
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  normal,
    input  logic  ready,
    input  logic  start_we,
    input  logic  start_bit,
    input  code_t adc_code,
    output logic  active,
    output logic  tick,
    output code_t result
);
    localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic          running;
    logic [CW-1:0] iv_cnt;
    logic          go;

    assign go     = start_we && start_bit && ready;
    assign active = running && normal;
    assign tick   = active && (iv_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !normal) begin
            running <= 1'b0;
        end else if (go) begin
            running <= 1'b1;
        end else if (start_we && !start_bit) begin
            running <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || go || !active) begin
            iv_cnt <= '0;
        end else if (iv_cnt == LAST) begin
            iv_cnt <= '0;
        end else begin
            iv_cnt <= iv_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (tick) begin
            result <= adc_code;
        end
    end
endmodule

// File: rtl/tsc_readmux.sv
module tsc_readmux
    import thermsense_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  mode_t             mode,
    input  logic              active,
    input  code_t             result,
    input  logic [DATA_W-1:0] trim0,
    input  logic [DATA_W-1:0] trim1,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_MODE):   rdata[1:0]        = mode;
            ADDR_W'(OFF_START):  rdata[0]          = active;
            ADDR_W'(OFF_RESULT): rdata[CODE_W-1:0] = result;
            ADDR_W'(OFF_STATUS): rdata[0]          = active;
            ADDR_W'(OFF_TRIM0):  rdata             = trim_view(trim0);
            ADDR_W'(OFF_TRIM1):  rdata             = trim_view(trim1);
            default:             rdata             = '0;
        endcase
    end
endmodule

// File: rtl/thermsense_ctrl.sv
module thermsense_ctrl
    import thermsense_pkg::*;
#(
    parameter int CLK_HZ = 100000000,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [11:0]       adc_code,
    input  logic [31:0]       trim0_word,
    input  logic [31:0]       trim1_word
);
    localparam int SETTLE_CYC   = int'(us_to_cycles(CLK_HZ, SETTLE_US));
    localparam int INTERVAL_CYC = int'(us_to_cycles(CLK_HZ, INTERVAL_US));

    mode_t  mode;
    phase_e phase;
    logic   normal, ready, active, tick;
    logic   mode_we, start_we;
    code_t  result;
    logic   pins_unused;

    assign mode_we     = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
    assign start_we    = bus_we && (bus_addr == ADDR_W'(OFF_START));
    assign normal      = mode.sense_en && mode.adc_en;
    assign pins_unused = ^{bus_wdata[31:2], trim0_word[30:12], trim1_word[30:12], phase};

    tsc_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wbits (bus_wdata[1:0]),
        .mode  (mode)
    );

    tsc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .normal (normal),
        .ready  (ready),
        .phase  (phase)
    );

    tsc_conv #(.INTERVAL_CYC(INTERVAL_CYC)) u_conv (
        .clk       (clk),
        .rst       (rst),
        .normal    (normal),
        .ready     (ready),
        .start_we  (start_we),
        .start_bit (bus_wdata[0]),
        .adc_code  (adc_code),
        .active    (active),
        .tick      (tick),
        .result    (result)
    );

    tsc_readmux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr   (bus_addr),
        .mode   (mode),
        .active (active),
        .result (result),
        .trim0  (trim0_word),
        .trim1  (trim1_word),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/thermsense_ctrl_chk.sv
module thermsense_ctrl_chk
    import thermsense_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [1:0]        wbits,
    input logic [30:12]      rdata_mid,
    input logic              ready,
    input logic              active,
    input logic              tick,
    input code_t             result
);
    logic start_wr, mode_wr, trim_rd;
    assign start_wr = bus_we && (bus_addr == ADDR_W'(OFF_START));
    assign mode_wr  = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
    assign trim_rd  = (bus_addr == ADDR_W'(OFF_TRIM0)) || (bus_addr == ADDR_W'(OFF_TRIM1));

    assert_early_start_R3: assert property (@(posedge clk) disable iff (rst)
        (start_wr && wbits[0] && !ready && !active) |=> !active);

    assert_start_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (start_wr && wbits[0] && ready) |=> active);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(result));

    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && (wbits != 2'b11)) |=> (!active && !ready));

    assert_stop_write_R8: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !wbits[0]) |=> !active);

    assert_trim_gap_R9: assert property (@(posedge clk) disable iff (rst)
        trim_rd |-> (rdata_mid == '0));
endmodule

bind thermsense_ctrl thermsense_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wbits     (bus_wdata[1:0]),
    .rdata_mid (bus_rdata[30:12]),
    .ready     (ready),
    .active    (active),
    .tick      (tick),
    .result    (result)
);

// File: tb/thermsense_ctrl_test.sv
module thermsense_ctrl_test;
    localparam int CLK_HZ   = 1000000;
    localparam int SETTLE   = (CLK_HZ / 1000000) * 60;
    localparam int INTERVAL = (CLK_HZ / 1000000) * 20;
    localparam int NCODES   = 8;
    localparam logic [11:0] CODES [NCODES] = '{12'h5A3, 12'hFFF, 12'h000, 12'h801,
                                               12'h7FE, 12'h123, 12'hC4C, 12'h1F7};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] adc_code = '0;
    logic [31:0] trim0_word = 32'h8ABC_DC4C;
    logic [31:0] trim1_word = 32'h7000_E1F7;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    thermsense_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .adc_code   (adc_code),
        .trim0_word (trim0_word),
        .trim1_word (trim1_word)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called near a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        bus_addr = a;
        #1;
        got = bus_rdata;
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr 0x%02h: actual 0x%08h expected 0x%08h", req, a, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(8'h00, 32'h0, "R1 mode");
        expect_reg(8'h04, 32'h0, "R1 start");
        expect_reg(8'h0C, 32'h0, "R1 result");
        expect_reg(8'h10, 32'h0, "R1 status");

        // R10 unmapped
        expect_reg(8'h08, 32'h0, "R10");
        expect_reg(8'h14, 32'h0, "R10");

        // R9 trim view and write immunity
        expect_reg(8'h18, 32'h8000_0C4C, "R9 trim0");
        expect_reg(8'h1C, 32'h0000_01F7, "R9 trim1");
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0);
        expect_reg(8'h18, 32'h8000_0C4C, "R9 trim0 after write");
        expect_reg(8'h1C, 32'h0000_01F7, "R9 trim1 after write");

        // R2 / R4: partial modes, start ignored
        wr(8'h00, 32'hFFFF_FFFD);
        expect_reg(8'h00, 32'h1, "R2 sensor only");
        wait_cyc(SETTLE + 2);
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h0, "R4 sensor only");
        wr(8'h00, 32'h2);
        expect_reg(8'h00, 32'h2, "R2 adc only");
        wait_cyc(SETTLE + 2);
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h0, "R4 adc only");

        // R3: start one edge early is ignored, start on time is taken
        wr(8'h00, 32'h3);
        expect_reg(8'h00, 32'h3, "R2 normal");
        wait_cyc(SETTLE - 2);
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h0, "R3 early start");
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h1, "R3/R5 status running");
        expect_reg(8'h04, 32'h1, "R5 start readback");

        // R6 table of ADC codes, checked one edge before and at each load
        begin
            logic [31:0] prev;
            prev = 32'h0;
            for (int i = 0; i < NCODES; i++) begin
                adc_code = CODES[i];
                wait_cyc(INTERVAL - 1);
                expect_reg(8'h0C, prev, "R6 before load");
                wait_cyc(1);
                expect_reg(8'h0C, {20'h0, CODES[i]}, "R6 at load");
                prev = {20'h0, CODES[i]};
            end
        end

        // R8 stop by writing start 0
        wr(8'h04, 32'h0);
        expect_reg(8'h10, 32'h0, "R8 status");
        adc_code = 12'hABC;
        wait_cyc(2 * INTERVAL + 3);
        expect_reg(8'h0C, 32'h0000_01F7, "R8 result held");

        // restart while still settled
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h1, "R3 restart while settled");
        wait_cyc(INTERVAL);
        expect_reg(8'h0C, 32'h0000_0ABC, "R6 after restart");

        // R7 mode clear stops, holds result, restarts warm-up
        wr(8'h00, 32'h1);
        expect_reg(8'h10, 32'h0, "R7 status after clear");
        adc_code = 12'h321;
        wait_cyc(2 * INTERVAL + 1);
        expect_reg(8'h0C, 32'h0000_0ABC, "R7 result held");
        wr(8'h00, 32'h3);
        wait_cyc(SETTLE - 2);
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h0, "R7 warm-up restarted");
        wr(8'h04, 32'h1);
        expect_reg(8'h10, 32'h1, "R7 start after new warm-up");
        wait_cyc(INTERVAL);
        expect_reg(8'h0C, 32'h0000_0321, "R7 capture resumes");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule